// File: doc/BRIEF.md
# System Control Register Bank with General-Purpose Outputs

This block is the byte-wide control register bank of a peripheral companion device. A host reaches it through an 8-bit offset space with a one-byte data path. Reads are combinational from the offset. A write takes effect on the rising clock edge where the write strobe is high. Wider registers are built from byte lanes, least significant byte at the lowest offset. A byte write replaces only its own lane.

The bank gathers eight sub-device interrupt lines into a status byte. A mask byte gates that status onto a single summary interrupt. It also drives a 16-line output port. The level driven on each line is its data bit ANDed with its output-enable bit. Every line whose driven level changes gives a one-cycle change pulse to the external handlers. Several further register groups have no behaviour of their own here and are only stored for read-back: routing, input-pin configuration and clock setup.

Top module: `scr_bank`

## Requirements
- R1: After a synchronous reset, every readable register reads zero except the revision byte. `irq_out`, `gpio_level` and `gpio_chg` are all zero.
- R2: When sub-interrupt line i differs from its value on the previous cycle, status bit i (offset 0x50, bit i) takes the new line value on the next edge.
- R3: `irq_out` is high exactly when the status byte ANDed with the mask byte (offset 0x52) is nonzero.
- R4: A write to offset 0x50 replaces every status bit whose line did not change in that cycle. A bit whose line changed in that same cycle takes the line value, not the written value.
- R5: `gpio_level` equals output data ANDed with output enable. It appears one clock after the write edge.
- R6: In the cycle where `gpio_level` takes a new value, `gpio_chg` is high for exactly the bits that changed. In the following cycle it is zero unless another change occurs.
- R7: Output data bits 7:0 sit at 0x78 and bits 15:8 at 0x79. Output-enable bits 7:0 sit at 0x7C and bits 15:8 at 0x7D. A write to one lane leaves the other lane unchanged, and each lane reads back as written.
- R8: The third lane of each port register (0x7A, 0x7E) would hold lines 16 to 23, which do not exist. Writes to it change neither the outputs nor any register, and it reads zero.
- R9: Storage-only bytes read back the last value written and are unaffected by writes elsewhere. These are routing (0x54), four three-byte input-pin groups starting at 0x64, 0x68, 0x6C and 0x70, and clock setup at 0x98 to 0x9F.
- R10: Every other offset reads zero, and writes to it have no effect.
- R11: Offset 0x08 always reads the revision parameter `REV_ID`, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sub_irq | input | NUM_SUB | Sub-device interrupt lines (0 NAND, 1 MMC, 2 USB host, 3 serial, 4 framebuffer) |
| irq_out | output | 1 | Summary interrupt |
| gpio_level | output | NUM_GPIO | Driven output level |
| gpio_chg | output | NUM_GPIO | Per-line one-cycle change pulse |

## Verification
Both a sub-interrupt line and a host write can update the status byte on the same edge. The bench provokes this by toggling two lines in the very cycle that writes a status byte with the opposite values on those bits and a set bit elsewhere. It then expects the toggled bits to follow the lines and the remaining bits to follow the write. The bench also sweeps the output port one lane at a time and compares level and change pulses against a data AND enable model.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam logic [7:0] OFF_REV   = 8'h08;
    localparam logic [7:0] OFF_STAT  = 8'h50;
    localparam logic [7:0] OFF_MASK  = 8'h52;
    localparam logic [7:0] OFF_ROUTE = 8'h54;
    localparam logic [7:0] OFF_GDATA = 8'h78;
    localparam logic [7:0] OFF_GOE   = 8'h7C;
    localparam logic [7:0] OFF_GPI   = 8'h64;
    localparam logic [7:0] OFF_CLK   = 8'h98;

    localparam int GPI_GROUPS = 4;
    localparam int GPI_STRIDE = 4;
    localparam int GPI_BYTES  = 3;
    localparam int CLK_BYTES  = 8;
    localparam int GP_SLOTS   = 3;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_req_t;

    function automatic logic in_window(logic [7:0] a, logic [7:0] base, int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/scr_byte_store.sv
module scr_byte_store
    import scr_pkg::*;
#(
    parameter logic [7:0] BASE   = 8'h98,
    parameter int         NBYTES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic [7:0] rdata
);
    localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [NBYTES*8-1:0] bytes_q;
    logic                hit;
    logic [AW-1:0]       idx;

    always_comb begin
        hit = in_window(req.addr, BASE, NBYTES);
        idx = AW'(req.addr - BASE);
    end

    always_ff @(posedge clk) begin
        if (rst)
            bytes_q <= '0;
        else if (req.wr && hit)
            bytes_q[idx*8 +: 8] <= req.data;
    end

    assign rdata = hit ? bytes_q[idx*8 +: 8] : 8'h00;

    // R9: bytes move only on a write that lands in this window
    assert_store_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && hit) |=> $stable(bytes_q));

endmodule

// File: rtl/scr_irq_agg.sv
module scr_irq_agg
    import scr_pkg::*;
#(
    parameter int NUM_SUB = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SUB-1:0] sub_lines,
    output logic [7:0]         rdata,
    output logic               irq_out
);
    logic [NUM_SUB-1:0] status_q, mask_q, route_q, line_q, line_edge;
    logic               wr_stat;

    assign line_edge = sub_lines ^ line_q;
    assign wr_stat   = req.wr && (req.addr == OFF_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            mask_q  <= '0;
            route_q <= '0;
        end else begin
            line_q <= sub_lines;
            if (req.wr && req.addr == OFF_MASK)  mask_q  <= req.data[NUM_SUB-1:0];
            if (req.wr && req.addr == OFF_ROUTE) route_q <= req.data[NUM_SUB-1:0];
        end
    end

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else if (line_edge[i])
                status_q[i] <= sub_lines[i];
            else if (wr_stat)
                status_q[i] <= req.data[i];
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (req.addr)
            OFF_STAT:  rdata = 8'(status_q);
            OFF_MASK:  rdata = 8'(mask_q);
            OFF_ROUTE: rdata = 8'(route_q);
            default:   rdata = 8'h00;
        endcase
    end

    assign irq_out = |(status_q & mask_q);

    // R2: a changed line lands in its status bit one edge later
    assert_line_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (sub_lines != line_q) |=>
            ((status_q ^ $past(sub_lines)) & $past(sub_lines ^ line_q)) == '0);

    // R3: summary interrupt cannot fire with every source masked
    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mask_q != '0));

    // R4: a status write with quiet lines takes the written value
    assert_stat_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && (sub_lines == line_q)) |=> (status_q == $past(req.data[NUM_SUB-1:0])));

endmodule

// File: rtl/scr_gpio_port.sv
module scr_gpio_port
    import scr_pkg::*;
#(
    parameter int NUM_GPIO = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    output logic [7:0]          rdata,
    output logic [NUM_GPIO-1:0] gpio_level,
    output logic [NUM_GPIO-1:0] gpio_chg
);
    localparam int NLANES = (NUM_GPIO + 7) / 8;
    localparam int PADW   = NLANES * 8;
    localparam int SW     = $clog2(GP_SLOTS + 1);

    logic [PADW-1:0]     data_q, oe_q;
    logic [NUM_GPIO-1:0] eff, level_q, chg_q;
    logic                dat_hit, oe_hit;
    logic [SW-1:0]       d_lane, o_lane;

    always_comb begin
        dat_hit = in_window(req.addr, OFF_GDATA, NLANES);
        oe_hit  = in_window(req.addr, OFF_GOE, NLANES);
        d_lane  = SW'(req.addr - OFF_GDATA);
        o_lane  = SW'(req.addr - OFF_GOE);
    end

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[l*8 +: 8] <= 8'h00;
                oe_q[l*8 +: 8]   <= 8'h00;
            end else if (req.wr) begin
                if (req.addr == OFF_GDATA + 8'(l)) data_q[l*8 +: 8] <= req.data;
                if (req.addr == OFF_GOE + 8'(l))   oe_q[l*8 +: 8]   <= req.data;
            end
        end
    end

    assign eff = data_q[NUM_GPIO-1:0] & oe_q[NUM_GPIO-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            chg_q   <= '0;
        end else begin
            level_q <= eff;
            chg_q   <= eff ^ level_q;
        end
    end

    always_comb begin
        if (dat_hit)     rdata = data_q[d_lane*8 +: 8];
        else if (oe_hit) rdata = oe_q[o_lane*8 +: 8];
        else             rdata = 8'h00;
    end

    assign gpio_level = level_q;
    assign gpio_chg   = chg_q;

    // R5: no line is driven high unless its enable was set
    assert_level_gated_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gpio_level & ~$past(oe_q[NUM_GPIO-1:0])) == '0));

    // R6: change pulses only where the driven level actually moved
    assert_chg_only_moved_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gpio_chg & ~(gpio_level ^ $past(gpio_level))) == '0));

    // R8: writes to the lane past the last line leave the port untouched
    assert_lane_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.addr == OFF_GDATA + 8'(NLANES) || req.addr == OFF_GOE + 8'(NLANES)))
            |=> ($stable(data_q) && $stable(oe_q)));

endmodule

// File: rtl/scr_bank.sv
module scr_bank
    import scr_pkg::*;
#(
    parameter int         NUM_GPIO = 16,
    parameter int         NUM_SUB  = 8,
    parameter logic [7:0] REV_ID   = 8'h5A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_SUB-1:0]  sub_irq,
    output logic                irq_out,
    output logic [NUM_GPIO-1:0] gpio_level,
    output logic [NUM_GPIO-1:0] gpio_chg
);
    bus_req_t   req;
    logic [7:0] irq_rd, gpio_rd, clk_rd;
    logic [7:0] gpi_rd [GPI_GROUPS];

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    scr_irq_agg #(.NUM_SUB(NUM_SUB)) u_irq (
        .clk(clk), .rst(rst), .req(req), .sub_lines(sub_irq),
        .rdata(irq_rd), .irq_out(irq_out)
    );

    scr_gpio_port #(.NUM_GPIO(NUM_GPIO)) u_gpio (
        .clk(clk), .rst(rst), .req(req), .rdata(gpio_rd),
        .gpio_level(gpio_level), .gpio_chg(gpio_chg)
    );

    for (genvar g = 0; g < GPI_GROUPS; g++) begin : g_gpi
        scr_byte_store #(
            .BASE(OFF_GPI + 8'(g * GPI_STRIDE)),
            .NBYTES(GPI_BYTES)
        ) u_store (
            .clk(clk), .rst(rst), .req(req), .rdata(gpi_rd[g])
        );
    end

    scr_byte_store #(.BASE(OFF_CLK), .NBYTES(CLK_BYTES)) u_clk (
        .clk(clk), .rst(rst), .req(req), .rdata(clk_rd)
    );

    always_comb begin
        bus_rdata = (bus_addr == OFF_REV) ? REV_ID : 8'h00;
        bus_rdata = bus_rdata | irq_rd | gpio_rd | clk_rd;
        for (int g = 0; g < GPI_GROUPS; g++)
            bus_rdata = bus_rdata | gpi_rd[g];
    end

endmodule

// File: tb/scr_bank_test.sv
module scr_bank_test;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] REV = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  sub_irq = 8'h00;
    logic        irq_out;
    logic [15:0] gpio_level, gpio_chg;

    int checks = 0;
    int failures = 0;

    logic [7:0]  mem [256];
    logic [7:0]  st_m = 8'h00;
    logic [7:0]  lines_m = 8'h00;
    logic [15:0] lvl_m = 16'h0000;

    scr_bank #(.NUM_GPIO(16), .NUM_SUB(8), .REV_ID(REV)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_irq(sub_irq),
        .irq_out(irq_out), .gpio_level(gpio_level), .gpio_chg(gpio_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit plain(int a);
        return a == 'h52 || a == 'h54 || (a >= 'h78 && a <= 'h79) || (a >= 'h7C && a <= 'h7D) ||
               (a >= 'h64 && a <= 'h66) || (a >= 'h68 && a <= 'h6A) ||
               (a >= 'h6C && a <= 'h6E) || (a >= 'h70 && a <= 'h72) ||
               (a >= 'h98 && a <= 'h9F);
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        if (a == 'h08) return REV;
        if (a == 'h50) return st_m;
        if (plain(a))  return mem[a];
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_lvl();
        return {mem['h79], mem['h78]} & {mem['h7D], mem['h7C]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (plain(int'(a))) mem[a] = d;
        if (a == 8'h50) st_m = d;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic set_lines(logic [7:0] v);
        @(negedge clk);
        sub_irq = v;
        st_m = (st_m & ~(v ^ lines_m)) | (v & (v ^ lines_m));
        lines_m = v;
        @(negedge clk);
    endtask

    task automatic sweep_all(string req);
        logic [7:0] d;
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            check(req, {24'h0, d}, {24'h0, exp_rd(a)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pat;
        logic [15:0] newl;
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs cleared and every offset at its reset value
        check("R1 irq", {31'h0, irq_out}, 32'h0);
        check("R1 level", {16'h0, gpio_level}, 32'h0);
        check("R1 chg", {16'h0, gpio_chg}, 32'h0);
        sweep_all("R1 reset read");

        // R5 R6 R7: lane-by-lane sweep of data and enable
        for (int k = 0; k < 16; k++) begin
            logic [7:0] a;
            case (k % 4)
                0: a = 8'h78;
                1: a = 8'h7C;
                2: a = 8'h79;
                default: a = 8'h7D;
            endcase
            wr(a, 8'((k * 59 + 23) ^ (k << 4)));
            newl = exp_lvl();
            @(negedge clk);
            check("R5 level", {16'h0, gpio_level}, {16'h0, newl});
            check("R6 chg", {16'h0, gpio_chg}, {16'h0, newl ^ lvl_m});
            lvl_m = newl;
            rd(a, d);
            check("R7 lane readback", {24'h0, d}, {24'h0, mem[a]});
        end
        @(negedge clk);
        check("R6 chg cleared", {16'h0, gpio_chg}, 32'h0);

        // R8: third lane is not a register
        wr(8'h7A, 8'hFF);
        @(negedge clk);
        check("R8 level after 7A", {16'h0, gpio_level}, {16'h0, lvl_m});
        check("R8 chg after 7A", {16'h0, gpio_chg}, 32'h0);
        wr(8'h7E, 8'hFF);
        @(negedge clk);
        check("R8 level after 7E", {16'h0, gpio_level}, {16'h0, lvl_m});
        rd(8'h7A, d); check("R8 read 7A", {24'h0, d}, 32'h0);
        rd(8'h7E, d); check("R8 read 7E", {24'h0, d}, 32'h0);

        // R2 R3: line patterns against a fixed mask
        wr(8'h52, 8'h35);
        for (int k = 0; k < 10; k++) begin
            pat = 8'(k * 29) ^ 8'h4C;
            set_lines(pat);
            rd(8'h50, d);
            check("R2 status", {24'h0, d}, {24'h0, st_m});
            check("R3 irq", {31'h0, irq_out}, {31'h0, |(st_m & mem['h52])});
        end
        wr(8'h52, 8'h00);
        check("R3 irq masked", {31'h0, irq_out}, 32'h0);
        wr(8'h52, 8'hFF);
        check("R3 irq unmasked", {31'h0, irq_out}, {31'h0, |st_m});

        // R4: plain status write, then write racing line changes
        wr(8'h50, 8'h3C);
        rd(8'h50, d);
        check("R4 status write", {24'h0, d}, 32'h3C);
        set_lines(8'h02);
        @(negedge clk);
        bus_addr = 8'h50; bus_wdata = 8'h82; bus_wr = 1'b1; sub_irq = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        lines_m = 8'h01;
        st_m = 8'h81;
        rd(8'h50, d);
        check("R4 same-cycle status", {24'h0, d}, 32'h81);
        check("R3 irq after race", {31'h0, irq_out}, 32'h1);

        // R9: storage-only bytes
        for (int a = 0; a < 256; a++)
            if (plain(a) && !((a >= 'h78 && a <= 'h7D) || a == 'h52))
                wr(8'(a), 8'(a) ^ 8'hC3);
        wr(8'h9D, 8'h11);
        sweep_all("R9 stored readback");

        // R10 R11: writes to unmapped offsets and the revision byte
        for (int a = 0; a < 256; a++)
            if (!plain(a) && a != 'h50)
                wr(8'(a), 8'hFF);
        @(negedge clk);
        check("R10 level after unmapped writes", {16'h0, gpio_level}, {16'h0, lvl_m});
        rd(8'h08, d);
        check("R11 revision", {24'h0, d}, {24'h0, REV});
        sweep_all("R10 full map");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule